// File: doc/BRIEF.md
# Microsecond Down-Counting Event Timer

This block is a register-mapped 32-bit time base. A programmable prescaler divides the core clock so that the main counter takes one step per prescaled tick. Software sets the divide value to the core clock frequency in Hz divided by 1,000,000, which gives one step per microsecond. The counter normally counts down and reloads from a load register when it passes zero. Software loads 0xFFFFFFFF and complements the count to get a rising microsecond time value.

Two events are latched into a raw status register. A timeout event occurs when the counter passes its terminal value. A match event occurs when a step brings the counter onto the match register. Each event has its own mask bit for the single level-sensitive interrupt output. Software clears either event by writing a one to the matching bit of a clear register. Writes take effect on the rising clock edge. Reads are combinational from the address and have no side effects.

Top module: `us_event_timer`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and irq_o is low. The word addresses are: control 0, config 1, mode 2, load 3, match 4, prescale 5, live count 6, mask 7, raw status 8, masked status 9, clear 10. The clear register always reads zero.
- R2: A prescale value P of 1 or more steps the counter once every P clock cycles, and P = 0 behaves as 1. The prescale phase restarts from zero when control bit 0 is written from 0 to 1.
- R3: Writing control bit 0 from 0 to 1 sets the count to the load value when counting down, or to zero when counting up. Each later tick lowers a down count by one.
- R4: In periodic mode (mode bits [1:0] = 2), a tick that finds a down count at zero reloads the load value and sets raw status bit 0.
- R5: With mode bit 4 set, the counter counts up from zero. A tick that finds the count equal to the load value wraps it to zero and sets raw status bit 0.
- R6: In one-shot mode (mode bits [1:0] = 1), the tick at the terminal value sets raw status bit 0. The count then holds that value and control bit 0 reads back as 0.
- R7: With mode bit 5 set, a tick that moves the count onto the match value sets raw status bit 4. With mode bit 5 clear, raw status bit 4 is never set.
- R8: A write to the clear register clears each raw status bit (0 and 4) that is 1 in the written data and leaves the others unchanged. When an event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R9: irq_o is high exactly while some raw status bit is set together with its mask bit (mask bits 0 and 4). It stays high until the bit is cleared.
- R10: The counter steps only when config reads 4. Any other config value holds the count.
- R11: Reading the live count or the match register changes nothing. Writing control bit 0 to 0 freezes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Word address of the register access |
| wr_en_i | input | 1 | Write strobe, takes effect at the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt: masked events present |

## Verification
The timeout event and a software write to the clear register can fall on the same clock edge for the same status bit. The bench runs a count of two with a prescale of one. It times the clear-register write so that its edge is exactly the edge where the zero count reloads. The raw status must then read back with bit 0 still set. A second clear write a few cycles later, with no event on its edge, must remove the bit.

// File: rtl/us_timer_pkg.sv
package us_timer_pkg;
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_CFG   = 1;
  localparam int unsigned REG_MODE  = 2;
  localparam int unsigned REG_LOAD  = 3;
  localparam int unsigned REG_MATCH = 4;
  localparam int unsigned REG_PRESC = 5;
  localparam int unsigned REG_VALUE = 6;
  localparam int unsigned REG_IMASK = 7;
  localparam int unsigned REG_RAW   = 8;
  localparam int unsigned REG_MIS   = 9;
  localparam int unsigned REG_CLEAR = 10;

  localparam logic [2:0] CFG_WIDE      = 3'd4;
  localparam logic [1:0] MODE_ONESHOT  = 2'd1;
  localparam logic [1:0] MODE_PERIODIC = 2'd2;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_SUB_BIT  = 8;
  localparam int unsigned MODE_UP_BIT   = 4;
  localparam int unsigned MODE_MTEN_BIT = 5;
  localparam int unsigned ST_TO_BIT     = 0;
  localparam int unsigned ST_MT_BIT     = 4;

  // internal event vector: [0] timeout, [1] match
  localparam int unsigned EV_N  = 2;
  localparam int unsigned EV_TO = 0;
  localparam int unsigned EV_MT = 1;
  typedef logic [EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/us_prescaler.sv
module us_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         restart_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  // div of 0 or 1 gives a tick each cycle
  always_comb last = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, div_i};

  assign tick_o = run_i & ~restart_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (last)                cnt_q <= '0;
    else                          cnt_q <= cnt_q + W'(1);
  end

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > W'(1) && $stable(div_i)) |=> !tick_o); // R2
  AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && div_i > W'(1)) |=> !tick_o); // R2
endmodule

// File: rtl/us_count_core.sv
module us_count_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic         up_i,
  input  logic         oneshot_i,
  input  logic         match_en_i,
  input  logic [W-1:0] load_i,
  input  logic [W-1:0] match_val_i,
  output logic [W-1:0] count_o,
  output logic         timeout_o,
  output logic         match_o,
  output logic         stop_o
);
  logic [W-1:0] count_q, nxt;
  logic         term;

  always_comb term = up_i ? (count_q == load_i) : (count_q == '0);

  always_comb begin
    nxt       = count_q;
    timeout_o = 1'b0;
    stop_o    = 1'b0;
    if (tick_i) begin
      if (term) begin
        timeout_o = 1'b1;
        if (oneshot_i) stop_o = 1'b1;
        else           nxt    = up_i ? '0 : load_i;
      end else begin
        nxt = up_i ? count_q + W'(1) : count_q - W'(1);
      end
    end
  end

  assign match_o = tick_i & match_en_i & (nxt == match_val_i);
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (start_i) count_q <= up_i ? '0 : load_i;
    else              count_q <= nxt;
  end

  AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !start_i && !up_i && count_q != '0) |=> count_q == $past(count_q) - W'(1)); // R3
  AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !start_i && !up_i && !oneshot_i && count_q == '0) |=> count_q == $past(load_i)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start_i) |=> $stable(count_q)); // R11
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !start_i) |=> $stable(count_q)); // R6
endmodule

// File: rtl/us_event_status.sv
module us_event_status
  import us_timer_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ev_vec_t set_i,
  input  logic    clr_wr_i,
  input  ev_vec_t clr_val_i,
  input  ev_vec_t mask_i,
  output ev_vec_t raw_o,
  output ev_vec_t mis_o,
  output logic    irq_o
);
  ev_vec_t raw_q, clr_eff;

  always_comb clr_eff = clr_wr_i ? clr_val_i : '0;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_eff) | set_i;
  end

  assign raw_o = raw_q;
  assign mis_o = raw_q & mask_i;
  assign irq_o = |mis_o;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[EV_TO] |=> raw_q[EV_TO]); // R8
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q[EV_MT] && !(clr_wr_i && clr_val_i[EV_MT])) |=> raw_q[EV_MT]); // R8
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_val_i[EV_TO] && !set_i[EV_TO]) |=> !raw_q[EV_TO]); // R8
endmodule

// File: rtl/us_event_timer.sv
module us_event_timer
  import us_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned PRESC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic               run_q, sub_q, up_q, mten_q;
  logic [2:0]         cfg_q;
  logic [1:0]         mfld_q;
  logic [DATA_W-1:0]  load_q, match_q, count_w;
  logic [PRESC_W-1:0] presc_q;
  ev_vec_t            imask_q, raw_w, mis_w, set_w, clr_val;
  logic               wr_ctrl, wr_clear, start, active, tick, stop, to_ev, mt_ev;

  always_comb begin
    wr_ctrl  = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
    wr_clear = wr_en_i && (addr_i == ADDR_W'(REG_CLEAR));
    start    = wr_ctrl && wr_data_i[CTRL_RUN_BIT] && !run_q;
    active   = run_q && (cfg_q == CFG_WIDE) &&
               (mfld_q == MODE_PERIODIC || mfld_q == MODE_ONESHOT);
    clr_val  = '0;
    clr_val[EV_TO] = wr_data_i[ST_TO_BIT];
    clr_val[EV_MT] = wr_data_i[ST_MT_BIT];
    set_w    = '0;
    set_w[EV_TO] = to_ev;
    set_w[EV_MT] = mt_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; sub_q <= 1'b0; cfg_q <= '0; mfld_q <= '0;
      up_q <= 1'b0; mten_q <= 1'b0; load_q <= '0; match_q <= '0;
      presc_q <= '0; imask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= wr_data_i[CTRL_RUN_BIT];
        sub_q <= wr_data_i[CTRL_SUB_BIT];
      end else if (stop) begin
        run_q <= 1'b0;
      end
      if (wr_en_i) begin
        case (32'(addr_i))
          REG_CFG:   cfg_q <= wr_data_i[2:0];
          REG_MODE:  begin
            mfld_q <= wr_data_i[1:0];
            up_q   <= wr_data_i[MODE_UP_BIT];
            mten_q <= wr_data_i[MODE_MTEN_BIT];
          end
          REG_LOAD:  load_q  <= wr_data_i;
          REG_MATCH: match_q <= wr_data_i;
          REG_PRESC: presc_q <= wr_data_i[PRESC_W-1:0];
          REG_IMASK: begin
            imask_q[EV_TO] <= wr_data_i[ST_TO_BIT];
            imask_q[EV_MT] <= wr_data_i[ST_MT_BIT];
          end
          default: ;
        endcase
      end
    end
  end

  us_prescaler #(.W(PRESC_W)) u_presc (
    .clk_i, .rst_ni, .run_i(active), .restart_i(start), .div_i(presc_q), .tick_o(tick)
  );

  us_count_core #(.W(DATA_W)) u_core (
    .clk_i, .rst_ni, .start_i(start), .tick_i(tick), .up_i(up_q),
    .oneshot_i(mfld_q == MODE_ONESHOT), .match_en_i(mten_q),
    .load_i(load_q), .match_val_i(match_q), .count_o(count_w),
    .timeout_o(to_ev), .match_o(mt_ev), .stop_o(stop)
  );

  us_event_status u_stat (
    .clk_i, .rst_ni, .set_i(set_w), .clr_wr_i(wr_clear), .clr_val_i(clr_val),
    .mask_i(imask_q), .raw_o(raw_w), .mis_o(mis_w), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (32'(addr_i))
      REG_CTRL: begin
        rd_data_o[CTRL_RUN_BIT] = run_q;
        rd_data_o[CTRL_SUB_BIT] = sub_q;
      end
      REG_CFG:   rd_data_o = DATA_W'(cfg_q);
      REG_MODE:  begin
        rd_data_o[1:0]           = mfld_q;
        rd_data_o[MODE_UP_BIT]   = up_q;
        rd_data_o[MODE_MTEN_BIT] = mten_q;
      end
      REG_LOAD:  rd_data_o = load_q;
      REG_MATCH: rd_data_o = match_q;
      REG_PRESC: rd_data_o = DATA_W'(presc_q);
      REG_VALUE: rd_data_o = count_w;
      REG_IMASK: begin
        rd_data_o[ST_TO_BIT] = imask_q[EV_TO];
        rd_data_o[ST_MT_BIT] = imask_q[EV_MT];
      end
      REG_RAW: begin
        rd_data_o[ST_TO_BIT] = raw_w[EV_TO];
        rd_data_o[ST_MT_BIT] = raw_w[EV_MT];
      end
      REG_MIS: begin
        rd_data_o[ST_TO_BIT] = mis_w[EV_TO];
        rd_data_o[ST_MT_BIT] = mis_w[EV_MT];
      end
      default: ;
    endcase
  end

  AST_ONESHOT_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !wr_ctrl) |=> !run_q); // R6
  AST_CFG_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != CFG_WIDE && !start) |=> $stable(count_w)); // R10
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clear && wr_data_i[ST_TO_BIT] && wr_data_i[ST_MT_BIT] && !to_ev && !mt_ev) |=> !irq_o); // R9
  AST_NO_MATCH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mten_q && !wr_clear && !raw_w[EV_MT]) |=> !raw_w[EV_MT]); // R7
endmodule

// File: tb/us_event_timer_bench.sv
module us_event_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam int A_CTRL = 0, A_CFG = 1, A_MODE = 2, A_LOAD = 3, A_MATCH = 4,
                 A_PRESC = 5, A_VALUE = 6, A_IMASK = 7, A_RAW = 8, A_MIS = 9, A_CLEAR = 10;

  always #4 clk = ~clk;

  us_event_timer u_us_event_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 4'(a);
    #1;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_and_clear();
    wr(A_CTRL, 0);
    wr(A_CLEAR, 32'h11);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a <= A_CLEAR; a++) begin
      rd(a, d);
      check("R1", $sformatf("reg %0d after reset", a), d, 0);
    end
    check("R1", "irq after reset", {31'b0, irq}, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d, v1;
    wr(A_CFG, 4); wr(A_MODE, 2); wr(A_LOAD, 5); wr(A_PRESC, 3);
    wr(A_CTRL, 1);
    rd(A_VALUE, d); check("R3", "count loaded at start", d, 5);
    wait_cyc(2); rd(A_VALUE, d); check("R2", "no step before P cycles", d, 5);
    wait_cyc(1); rd(A_VALUE, d); check("R2", "first step after P cycles", d, 4);
    wait_cyc(12); rd(A_VALUE, d); check("R3", "count reaches zero", d, 0);
    rd(A_RAW, d); check("R4", "no timeout at zero yet", d, 0);
    wait_cyc(3); rd(A_VALUE, d); check("R4", "reload after zero", d, 5);
    rd(A_RAW, d); check("R4", "timeout bit set", d, 32'h1);
    check("R9", "irq low while masked", {31'b0, irq}, 0);
    wr(A_IMASK, 32'h1);
    check("R9", "irq high once unmasked", {31'b0, irq}, 1);
    rd(A_MIS, d); check("R9", "masked status", d, 32'h1);
    wr(A_CLEAR, 32'h1);
    rd(A_RAW, d); check("R8", "timeout cleared", d, 0);
    check("R9", "irq low after clear", {31'b0, irq}, 0);
    wr(A_CTRL, 0);
    rd(A_VALUE, v1); wait_cyc(5); rd(A_VALUE, d);
    check("R11", "count frozen and reads side-effect free", d, v1);
    wr(A_IMASK, 0);
    stop_and_clear();
  endtask

  task automatic t_presc_zero();
    logic [31:0] d;
    wr(A_PRESC, 0); wr(A_LOAD, 3); wr(A_CTRL, 1);
    wait_cyc(1); rd(A_VALUE, d); check("R2", "P=0 steps each cycle", d, 2);
    wait_cyc(2); rd(A_VALUE, d); check("R2", "P=0 at zero", d, 0);
    wait_cyc(1); rd(A_VALUE, d); check("R4", "P=0 reload", d, 3);
    rd(A_RAW, d); check("R4", "P=0 timeout", d, 32'h1);
    stop_and_clear();
  endtask

  task automatic t_up();
    logic [31:0] d;
    wr(A_MODE, 32'h12); wr(A_LOAD, 4); wr(A_PRESC, 1); wr(A_CTRL, 1);
    rd(A_VALUE, d); check("R5", "up starts at zero", d, 0);
    wait_cyc(4); rd(A_VALUE, d); check("R5", "up reaches load", d, 4);
    rd(A_RAW, d); check("R5", "no timeout before wrap", d, 0);
    wait_cyc(1); rd(A_VALUE, d); check("R5", "up wraps to zero", d, 0);
    rd(A_RAW, d); check("R5", "timeout on wrap", d, 32'h1);
    stop_and_clear();
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(A_MODE, 1); wr(A_LOAD, 2); wr(A_PRESC, 1); wr(A_CTRL, 1);
    wait_cyc(2); rd(A_RAW, d); check("R6", "no timeout at zero yet", d, 0);
    wait_cyc(1); rd(A_RAW, d); check("R6", "one-shot timeout", d, 32'h1);
    rd(A_CTRL, d); check("R6", "run bit cleared", d, 0);
    wait_cyc(4); rd(A_VALUE, d); check("R6", "count holds at zero", d, 0);
    stop_and_clear();
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(A_MODE, 32'h22); wr(A_LOAD, 10); wr(A_MATCH, 7); wr(A_PRESC, 1);
    wr(A_IMASK, 32'h10); wr(A_CTRL, 1);
    wait_cyc(2); rd(A_RAW, d); check("R7", "no match at 8", d, 0);
    check("R9", "irq low before match", {31'b0, irq}, 0);
    wait_cyc(1); rd(A_RAW, d); check("R7", "match at 7", d, 32'h10);
    check("R9", "irq on match", {31'b0, irq}, 1);
    rd(A_MATCH, d); check("R11", "match register readback", d, 7);
    wait_cyc(8); rd(A_RAW, d); check("R4", "timeout plus match", d, 32'h11);
    wr(A_CLEAR, 32'h10);
    rd(A_RAW, d); check("R8", "clear only bit 4", d, 32'h1);
    wr(A_IMASK, 0);
    stop_and_clear();
    wr(A_MODE, 2); wr(A_CTRL, 1);
    wait_cyc(3); rd(A_RAW, d); check("R7", "match disabled", d, 0);
    stop_and_clear();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(A_MODE, 2); wr(A_LOAD, 2); wr(A_PRESC, 1); wr(A_CTRL, 1);
    wait_cyc(1);
    wr(A_CLEAR, 32'h1); // lands on the reload edge
    rd(A_RAW, d); check("R8", "set wins over same-cycle clear", d, 32'h1);
    wr(A_CTRL, 0); wr(A_CLEAR, 32'h1);
    rd(A_RAW, d); check("R8", "later clear removes bit", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(A_CFG, 0); wr(A_LOAD, 6); wr(A_PRESC, 1); wr(A_CTRL, 1);
    wait_cyc(5); rd(A_VALUE, d); check("R10", "held without 32-bit config", d, 6);
    wr(A_CFG, 4);
    rd(A_VALUE, d); check("R10", "still held on config edge", d, 6);
    wait_cyc(1); rd(A_VALUE, d); check("R10", "steps after config 4", d, 5);
    stop_and_clear();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_periodic();
    t_presc_zero();
    t_up();
    t_oneshot();
    t_match();
    t_collide();
    t_cfg();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule